// File: doc/BRIEF.md
# Embedded-Sync 4:2:2 Video Byte Formatter

The formatter accepts decoded 4:2:2 video one pixel at a time and turns it into a single 8-bit byte stream with two bytes per pixel, chroma first and luma second. Each pixel carries its luma value, both colour-difference values and three timing flags: horizontal active, vertical active and field. Cb goes with the even pixels of an active run and Cr with the odd ones, so a run reads Cb, Y, Cr, Y, Cb, Y and so on.

In embedded mode the block writes the timing codes into the stream itself. The first two blanking pixels after an active run become the end-of-active code. The last two pixels of the standard's horizontal blanking become the start-of-active code. The blanking is 138 pixels (276 bytes) for 525-line operation and 144 pixels (288 bytes) for 625-line operation, so a full 720-pixel line spans 1716 or 1728 bytes. In pin-sync mode no codes are sent. The same byte order is framed by a separate horizontal-valid output instead. Blanking bytes are filled with neutral values. An option lets the luma of blanking pixels through.

Both sides use valid/ready. A pixel is taken when `in_valid` and `in_ready` are both high at a clock edge. A byte leaves when `out_valid` and `out_ready` are both high. While `out_ready` is low the byte on the output is held unchanged and no new pixel is taken. The upstream source may pause at any time. The line position is counted in accepted pixels, not in clock cycles, so stalls on either side never change the stream.

Top module: `fmt656_tx`

## Requirements
- R1: After reset `out_valid` is low and `in_ready` is high.
- R2: Each accepted pixel yields exactly two output bytes, chroma then luma. In an active run Cb is used for even pixels and Cr for odd pixels, and the parity restarts at Cb with the first pixel of every active run.
- R3: In embedded mode (`embed_en`=1), the first two blanking pixels after an active pixel give the bytes FF, 00, 00, XY with H=1. No end-of-active code is produced before the first active-to-blanking transition after reset.
- R4: In embedded mode, blanking pixels number 136 and 137 (counted from 0 after the last active pixel) with `pal_mode`=0, or 142 and 143 with `pal_mode`=1, give FF, 00, 00, XY with H=0. A 720-pixel line with 138 or 144 blanking pixels therefore spans 1716 or 1728 bytes from one end-of-active code to the next.
- R5: The XY byte is {1, F, V, H, V^H, F^H, F^V, F^V^H}, from bit 7 down to bit 0. F is `in_field` and V is the inverse of `in_vact`, both taken from the pixel that carries the XY byte.
- R6: Pixels that are neither code pixels nor active (`in_hact`=1 and `in_vact`=1) are fill: the chroma byte is 0x80 and the luma byte is 0x10.
- R7: With `blank_y_pass`=1, the luma byte of a fill pixel is the pixel's clipped `in_y` instead of 0x10.
- R8: Video bytes taken from the inputs are clipped so that 0x00 becomes 0x01 and 0xFF becomes 0xFE. This applies to Y, Cb and Cr.
- R9: In pin-sync mode (`embed_en`=0) no code bytes are inserted, so 0xFF never appears on the output. `out_hvalid` equals the `in_hact` of the pixel whose bytes are on the output, in both modes.
- R10: While `out_valid` is high and `out_ready` is low, `out_data` and `out_hvalid` hold their values. A pixel accepted at an edge has its chroma byte on the output after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| embed_en | input | 1 | 1: insert timing codes; 0: pin-sync framing |
| pal_mode | input | 1 | 1: 625-line blanking length; 0: 525-line |
| blank_y_pass | input | 1 | 1: pass luma through in fill pixels |
| in_valid | input | 1 | Pixel available |
| in_ready | output | 1 | Pixel accepted when high with in_valid |
| in_y | input | 8 | Luma sample |
| in_cb | input | 8 | Blue colour-difference sample |
| in_cr | input | 8 | Red colour-difference sample |
| in_hact | input | 1 | Pixel lies in the horizontal active run |
| in_vact | input | 1 | Pixel lies on an active line |
| in_field | input | 1 | Field flag of the pixel |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream takes the byte |
| out_data | output | 8 | Output byte stream |
| out_hvalid | output | 1 | Horizontal-active flag of the byte's pixel |

## Verification
Two things can fall in the same cycle: the last byte of one pixel leaving and the next pixel being accepted. When that next pixel is a code pixel, a stalled output must not change the code byte or advance the blanking count. The bench provokes this by toggling `out_ready` with a pseudo-random pattern and inserting input bubbles across the end-of-active and start-of-active boundaries. It then compares the whole captured byte stream with a stream built from the requirements alone. Any lost or repeated byte shifts every later position, so the comparison fails.

// File: rtl/fmt656_pkg.sv
package fmt656_pkg;

  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] FILL_CHROMA = 8'h80;
  localparam logic [BYTE_W-1:0] FILL_LUMA   = 8'h10;
  localparam logic [BYTE_W-1:0] CODE_HI     = 8'hFF;
  localparam logic [BYTE_W-1:0] CODE_LO     = 8'h00;

  typedef enum logic [2:0] {
    PX_ACT,
    PX_FILL,
    PX_EAV0,
    PX_EAV1,
    PX_SAV0,
    PX_SAV1
  } px_kind_t;

  function automatic logic [BYTE_W-1:0] xy_code(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  function automatic logic [BYTE_W-1:0] clip_video(input logic [BYTE_W-1:0] x);
    if (x == CODE_LO)      return 8'h01;
    else if (x == CODE_HI) return 8'hFE;
    else                   return x;
  endfunction

endpackage

// File: rtl/fmt656_line_track.sv
module fmt656_line_track
  import fmt656_pkg::*;
#(
  parameter int NTSC_BLANK = 138,
  parameter int PAL_BLANK  = 144,
  parameter int CW         = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     step,
  input  logic     hact,
  input  logic     vact,
  input  logic     embed_en,
  input  logic     pal_mode,
  output px_kind_t kind,
  output logic     use_cr
);

  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};
  localparam logic [CW-1:0] ONE     = CW'(1);
  localparam logic [CW-1:0] TWO     = CW'(2);

  logic          prev_act;
  logic          par_q;
  logic [CW-1:0] bcnt;
  logic [CW-1:0] idx;
  logic [CW-1:0] blen;
  logic          cur_par;

  assign blen    = pal_mode ? CW'(PAL_BLANK) : CW'(NTSC_BLANK);
  assign idx     = prev_act ? '0 : bcnt;
  assign cur_par = prev_act & par_q;
  assign use_cr  = cur_par;

  always_comb begin
    if (hact)                 kind = vact ? PX_ACT : PX_FILL;
    else if (!embed_en)       kind = PX_FILL;
    else if (prev_act)        kind = PX_EAV0;
    else if (idx == ONE)      kind = PX_EAV1;
    else if (idx == blen - TWO) kind = PX_SAV0;
    else if (idx == blen - ONE) kind = PX_SAV1;
    else                      kind = PX_FILL;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_act <= 1'b0;
      par_q    <= 1'b0;
      bcnt     <= CNT_MAX;
    end else if (step) begin
      prev_act <= hact;
      if (hact) begin
        par_q <= ~cur_par;
      end else if (prev_act) begin
        bcnt <= ONE;
      end else if (bcnt != CNT_MAX) begin
        bcnt <= bcnt + ONE;
      end
    end
  end

  // R3
  eav_count_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && kind == PX_EAV0) |=> (!prev_act && bcnt == ONE));

  // R2
  parity_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && hact && !prev_act) |=> (prev_act && par_q));

endmodule

// File: rtl/fmt656_pair_build.sv
module fmt656_pair_build
  import fmt656_pkg::*;
(
  input  px_kind_t          kind,
  input  logic              use_cr,
  input  logic              y_pass,
  input  logic              vact,
  input  logic              field,
  input  logic [BYTE_W-1:0] y,
  input  logic [BYTE_W-1:0] cb,
  input  logic [BYTE_W-1:0] cr,
  output logic [BYTE_W-1:0] b0,
  output logic [BYTE_W-1:0] b1
);

  always_comb begin
    b0 = FILL_CHROMA;
    b1 = y_pass ? clip_video(y) : FILL_LUMA;
    unique case (kind)
      PX_ACT: begin
        b0 = clip_video(use_cr ? cr : cb);
        b1 = clip_video(y);
      end
      PX_EAV0, PX_SAV0: begin
        b0 = CODE_HI;
        b1 = CODE_LO;
      end
      PX_EAV1: begin
        b0 = CODE_LO;
        b1 = xy_code(field, ~vact, 1'b1);
      end
      PX_SAV1: begin
        b0 = CODE_LO;
        b1 = xy_code(field, ~vact, 1'b0);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/fmt656_pair_ser.sv
module fmt656_pair_ser
  import fmt656_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] byte0,
  input  logic [BYTE_W-1:0] byte1,
  input  logic              hv,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_hvalid
);

  logic              hold;
  logic              phase;
  logic [BYTE_W-1:0] b0_q;
  logic [BYTE_W-1:0] b1_q;
  logic              hv_q;
  logic              load;

  assign in_ready   = !hold || (phase && out_ready);
  assign load       = in_valid && in_ready;
  assign out_valid  = hold;
  assign out_data   = phase ? b1_q : b0_q;
  assign out_hvalid = hv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold  <= 1'b0;
      phase <= 1'b0;
      b0_q  <= '0;
      b1_q  <= '0;
      hv_q  <= 1'b0;
    end else if (load) begin
      hold  <= 1'b1;
      phase <= 1'b0;
      b0_q  <= byte0;
      b1_q  <= byte1;
      hv_q  <= hv;
    end else if (hold && out_ready) begin
      if (!phase) phase <= 1'b1;
      else        hold  <= 1'b0;
    end
  end

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_hvalid)));

  // R10
  load_show_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_data == $past(byte0)));

endmodule

// File: rtl/fmt656_tx.sv
module fmt656_tx
  import fmt656_pkg::*;
#(
  parameter int NTSC_BLANK = 138,
  parameter int PAL_BLANK  = 144,
  parameter int CW         = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       embed_en,
  input  logic       pal_mode,
  input  logic       blank_y_pass,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_y,
  input  logic [7:0] in_cb,
  input  logic [7:0] in_cr,
  input  logic       in_hact,
  input  logic       in_vact,
  input  logic       in_field,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_hvalid
);

  px_kind_t          kind;
  logic              use_cr;
  logic              step;
  logic [BYTE_W-1:0] pb0;
  logic [BYTE_W-1:0] pb1;

  assign step = in_valid && in_ready;

  fmt656_line_track #(
    .NTSC_BLANK(NTSC_BLANK),
    .PAL_BLANK (PAL_BLANK),
    .CW        (CW)
  ) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (step),
    .hact    (in_hact),
    .vact    (in_vact),
    .embed_en(embed_en),
    .pal_mode(pal_mode),
    .kind    (kind),
    .use_cr  (use_cr)
  );

  fmt656_pair_build u_build (
    .kind  (kind),
    .use_cr(use_cr),
    .y_pass(blank_y_pass),
    .vact  (in_vact),
    .field (in_field),
    .y     (in_y),
    .cb    (in_cb),
    .cr    (in_cr),
    .b0    (pb0),
    .b1    (pb1)
  );

  fmt656_pair_ser u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .byte0     (pb0),
    .byte1     (pb1),
    .hv        (in_hact),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_hvalid(out_hvalid)
  );

  // R8
  active_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && kind == PX_ACT) |->
      (pb0 != 8'h00 && pb0 != 8'hFF && pb1 != 8'h00 && pb1 != 8'hFF));

  // R9
  pin_no_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !embed_en) |-> (pb0 != 8'hFF && pb1 != 8'hFF));

endmodule

// File: tb/fmt656_tx_test.sv
module fmt656_tx_test;

  localparam int CLK_PERIOD = 10;
  localparam int MAXPX = 2000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       embed_en = 1'b1;
  logic       pal_mode = 1'b0;
  logic       blank_y_pass = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_y = '0, in_cb = '0, in_cr = '0;
  logic       in_hact = 1'b0, in_vact = 1'b0, in_field = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;
  logic       out_hvalid;

  int checks = 0;
  int fails = 0;

  logic [7:0] px_y [MAXPX], px_cb [MAXPX], px_cr [MAXPX];
  logic       px_h [MAXPX], px_v [MAXPX], px_f [MAXPX];
  int         npx;
  logic [7:0] got_b [2*MAXPX], exp_b [2*MAXPX];
  logic       got_h [2*MAXPX], exp_h [2*MAXPX];
  int         nb;
  logic       bp_en = 1'b0;
  logic       gap_en = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  always #(CLK_PERIOD/2) clk = ~clk;

  fmt656_tx uut (
    .clk(clk), .rst_n(rst_n), .embed_en(embed_en), .pal_mode(pal_mode),
    .blank_y_pass(blank_y_pass), .in_valid(in_valid), .in_ready(in_ready),
    .in_y(in_y), .in_cb(in_cb), .in_cr(in_cr), .in_hact(in_hact),
    .in_vact(in_vact), .in_field(in_field), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_hvalid(out_hvalid)
  );

  function automatic logic [7:0] clipv(input logic [7:0] x);
    if (x == 8'h00) return 8'h01;
    if (x == 8'hFF) return 8'hFE;
    return x;
  endfunction

  function automatic logic [7:0] xyv(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic add_px(input logic h, input logic v, input logic f,
                        input logic [7:0] y, input logic [7:0] cb, input logic [7:0] cr);
    px_h[npx] = h; px_v[npx] = v; px_f[npx] = f;
    px_y[npx] = y; px_cb[npx] = cb; px_cr[npx] = cr;
    npx++;
  endtask

  task automatic add_run(input int n, input logic h, input logic v, input logic f,
                         input logic [7:0] y, input logic [7:0] cb, input logic [7:0] cr);
    for (int i = 0; i < n; i++) add_px(h, v, f, y + 8'(i), cb, cr);
  endtask

  // Expected stream from the requirements (R2..R9)
  task automatic build_expect();
    logic prev = 1'b0;
    logic par = 1'b0;
    int   bc = 255;
    int   bl = pal_mode ? 144 : 138;
    for (int i = 0; i < npx; i++) begin
      logic [7:0] c0, c1;
      int idx;
      exp_h[2*i] = px_h[i]; exp_h[2*i+1] = px_h[i];
      c0 = 8'h80;
      c1 = blank_y_pass ? clipv(px_y[i]) : 8'h10;
      if (px_h[i]) begin
        logic p;
        p = prev ? par : 1'b0;
        if (px_v[i]) begin
          c0 = clipv(p ? px_cr[i] : px_cb[i]);
          c1 = clipv(px_y[i]);
        end
        par = ~p;
        prev = 1'b1;
      end else begin
        idx = prev ? 0 : bc;
        if (embed_en) begin
          if (prev) begin c0 = 8'hFF; c1 = 8'h00; end
          else if (idx == 1) begin c0 = 8'h00; c1 = xyv(px_f[i], ~px_v[i], 1'b1); end
          else if (idx == bl - 2) begin c0 = 8'hFF; c1 = 8'h00; end
          else if (idx == bl - 1) begin c0 = 8'h00; c1 = xyv(px_f[i], ~px_v[i], 1'b0); end
        end
        bc = prev ? 1 : ((bc >= 255) ? 255 : bc + 1);
        prev = 1'b0;
      end
      exp_b[2*i] = c0; exp_b[2*i+1] = c1;
    end
  endtask

  task automatic drive_all();
    int i = 0;
    while (i < npx) begin
      logic acc;
      @(negedge clk);
      if (gap_en && lfsr[2] && lfsr[5]) begin
        in_valid = 1'b0;
        #1;
        acc = 1'b0;
      end else begin
        in_valid = 1'b1;
        in_y = px_y[i]; in_cb = px_cb[i]; in_cr = px_cr[i];
        in_hact = px_h[i]; in_vact = px_v[i]; in_field = px_f[i];
        #1;
        acc = in_ready;
      end
      @(posedge clk);
      if (acc) i++;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic collect_all();
    nb = 0;
    while (nb < 2 * npx) begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = bp_en ? (lfsr[0] | lfsr[1]) : 1'b1;
      #1;
      if (out_valid && out_ready) begin
        got_b[nb] = out_data;
        got_h[nb] = out_hvalid;
        nb++;
      end
      @(posedge clk);
    end
    @(negedge clk);
    out_ready = 1'b1;
  endtask

  task automatic run_and_compare(input string req);
    build_expect();
    fork
      drive_all();
      collect_all();
    join
    for (int k = 0; k < 2 * npx; k++) begin
      check(req, $sformatf("byte %0d", k), got_b[k], exp_b[k]);
      check("R9", $sformatf("hvalid %0d", k), got_h[k], exp_h[k]);
    end
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    check("R1", "out_valid after reset", out_valid, 0);
    check("R1", "in_ready after reset", in_ready, 1);
  endtask

  task automatic t_ntsc_line();
    do_reset();
    embed_en = 1; pal_mode = 0; blank_y_pass = 0; bp_en = 0; gap_en = 0;
    npx = 0;
    add_run(720, 1, 1, 0, 8'h20, 8'h30, 8'h70);
    add_run(138, 0, 1, 0, 8'h50, 8'h90, 8'h90);
    add_run(720, 1, 1, 0, 8'h21, 8'h31, 8'h71);
    add_run(2, 0, 1, 0, 8'h50, 8'h90, 8'h90);
    run_and_compare("R2 R3 R4");
    check("R3", "eav byte0", got_b[1440], 8'hFF);
    check("R3", "eav byte1", got_b[1441], 8'h00);
    check("R3", "eav byte2", got_b[1442], 8'h00);
    check("R5", "eav xy F0V0", got_b[1443], 8'h9D);
    check("R4", "sav byte0", got_b[1712], 8'hFF);
    check("R5", "sav xy F0V0", got_b[1715], 8'h80);
    check("R4", "next eav after 1716", got_b[3156], 8'hFF);
    check("R4", "next eav xy", got_b[3159], 8'h9D);
    check("R2", "first chroma is Cb", got_b[0], 8'h30);
    check("R2", "second chroma is Cr", got_b[2], 8'h70);
  endtask

  task automatic t_pal_vblank();
    do_reset();
    embed_en = 1; pal_mode = 1; blank_y_pass = 0; bp_en = 0; gap_en = 0;
    npx = 0;
    add_run(30, 1, 0, 1, 8'h40, 8'h50, 8'h60);
    add_run(144, 0, 0, 1, 8'h40, 8'h50, 8'h60);
    add_run(30, 1, 0, 1, 8'h40, 8'h50, 8'h60);
    add_run(2, 0, 0, 1, 8'h40, 8'h50, 8'h60);
    run_and_compare("R4 R6");
    check("R6", "vblank chroma fill", got_b[0], 8'h80);
    check("R6", "vblank luma fill", got_b[1], 8'h10);
    check("R5", "eav xy F1V1", got_b[63], 8'hF1);
    check("R4", "pal sav byte0", got_b[344], 8'hFF);
    check("R5", "sav xy F1V1", got_b[347], 8'hEC);
    check("R4", "pal next eav", got_b[408], 8'hFF);
  endtask

  task automatic t_clip_pass();
    do_reset();
    embed_en = 1; pal_mode = 0; blank_y_pass = 1; bp_en = 0; gap_en = 0;
    npx = 0;
    add_px(1, 1, 0, 8'h00, 8'h00, 8'hFF);
    add_px(1, 1, 0, 8'hFF, 8'h00, 8'hFF);
    add_px(1, 1, 0, 8'h55, 8'h00, 8'hFF);
    add_run(138, 0, 1, 0, 8'hFF, 8'h22, 8'h22);
    for (int i = 3; i < 141; i++) px_y[i] = 8'hFF;
    add_run(3, 1, 1, 0, 8'h60, 8'h40, 8'hC0);
    run_and_compare("R7 R8");
    check("R8", "Cb 00 clipped", got_b[0], 8'h01);
    check("R8", "Y 00 clipped", got_b[1], 8'h01);
    check("R8", "Cr FF clipped", got_b[2], 8'hFE);
    check("R8", "Y FF clipped", got_b[3], 8'hFE);
    check("R2", "pixel 2 back to Cb", got_b[4], 8'h01);
    check("R7", "fill chroma", got_b[10], 8'h80);
    check("R7", "fill luma passes clipped Y", got_b[11], 8'hFE);
    check("R2", "parity restarts on Cb", got_b[282], 8'h40);
    check("R2", "then Cr", got_b[284], 8'hC0);
  endtask

  task automatic t_pin_mode();
    int ff_seen = 0;
    do_reset();
    embed_en = 0; pal_mode = 0; blank_y_pass = 0; bp_en = 1; gap_en = 1;
    npx = 0;
    add_run(10, 1, 1, 0, 8'h30, 8'h44, 8'h88);
    add_run(138, 0, 1, 0, 8'h30, 8'h44, 8'h88);
    add_run(10, 1, 1, 0, 8'h30, 8'h44, 8'h88);
    run_and_compare("R9");
    for (int k = 0; k < 2 * npx; k++) if (got_b[k] == 8'hFF) ff_seen++;
    check("R9", "no FF bytes in pin mode", ff_seen, 0);
    check("R9", "hvalid low in blanking", got_h[20], 0);
  endtask

  task automatic t_backpressure();
    do_reset();
    embed_en = 1; pal_mode = 0; blank_y_pass = 0; bp_en = 1; gap_en = 1;
    npx = 0;
    add_run(8, 1, 1, 0, 8'h11, 8'h22, 8'h33);
    add_run(138, 0, 1, 0, 8'h11, 8'h22, 8'h33);
    add_run(8, 1, 1, 1, 8'h12, 8'h23, 8'h34);
    add_run(2, 0, 1, 1, 8'h11, 8'h22, 8'h33);
    run_and_compare("R10");
    check("R10", "eav position under stalls", got_b[16], 8'hFF);
    check("R5", "sav xy under stalls", got_b[16 + 275], 8'h80);
    check("R5", "eav xy F1V0", got_b[16 + 292 + 3], 8'hDA);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    t_reset();
    t_ntsc_line();
    t_pal_vblank();
    t_clip_pass();
    t_pin_mode();
    t_backpressure();
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    summary();
    $finish;
  end

endmodule